// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the arithmetic and logic stage of an integer execution unit. It combines two operands with one of eight operations and drives the result combinationally in the same cycle. Beside the datapath sits a four-bit condition code register (zero, negative, carry, overflow). It captures flags derived from the current result on a clock edge, but only when the caller asks for an update or the operation is a compare.

The carry-consuming operations read the carry bit stored at the previous edge. This lets a wide add or subtract be chained across several cycles, one word at a time. A compare is a subtract that produces flags only, and it marks its result as not to be written back. Register-file access, immediate decoding, shifts, multiply and divide belong to other blocks. The operand width is a parameter (default 32).

Top module: `intu_alu`

## Requirements
- R1: While `rst_ni` is low, all four condition flags read 0. Reset is asynchronous and active-low.
- R2: The flags change only at a rising clock edge where `upd_cc_i` is 1 or `op_i` is the compare code 7. In any other cycle they keep their value.
- R3: On an update, Z becomes 1 exactly when the result of that cycle is all zeros.
- R4: On an update, N becomes the most significant bit of the result of that cycle.
- R5: Code 0 (add) gives `opa_i + opb_i` and code 2 (add with carry) gives `opa_i + opb_i + C`, both modulo 2^W. On an update, C is the carry out of the top bit and V is 1 when the signed sum lies outside the signed W-bit range.
- R6: Code 1 (subtract) gives `opa_i - opb_i` and code 3 (subtract with borrow) gives `opa_i - opb_i - C`, both modulo 2^W. On an update, C is 1 when the unsigned difference would be negative (a borrow), and V is 1 when the signed difference lies outside the signed W-bit range.
- R7: Codes 2 and 3 use the C flag as held in the register during that cycle, that is, as left by the most recent update.
- R8: Code 4 gives bitwise AND, code 5 bitwise OR, and code 6 `opa_i` ORed with the complement of `opb_i`. An update after any of these clears C and V.
- R9: Code 7 (compare) drives the difference `opa_i - opb_i` on `result_o` with `res_valid_o` low. It updates all four flags as a subtract would, whatever the value of `upd_cc_i`. Every other code drives `res_valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 add carry, 3 sub borrow, 4 and, 5 or, 6 or-not, 7 compare) |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand, register value or sign-extended immediate |
| upd_cc_i | input | 1 | Request a condition code update at the next edge |
| result_o | output | W | Combinational result |
| res_valid_o | output | 1 | Result is to be written back (low for compare) |
| z_o | output | 1 | Stored zero flag |
| n_o | output | 1 | Stored negative flag |
| c_o | output | 1 | Stored carry/borrow flag |
| v_o | output | 1 | Stored overflow flag |

## Verification
On every cycle the assertions check the following: flags hold when no update is requested, Z and N track the previous result, logic updates clear C and V, add overflow follows the operand and result signs, and a compare never flags its result for write-back. Only the bench's scenarios show the full arithmetic. The bench sweeps every operand pair of a 4-bit instance under every operation and both stored carry values, which covers carry and borrow chaining, the signed overflow boundaries, and a compare issued with the update request low.

// File: rtl/intu_alu_pkg.sv
package intu_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDX = 3'd2,
    OP_SUBX = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_ORN  = 3'd6,
    OP_CMP  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } ccr_t;

  localparam ccr_t CCR_CLEAR = '{z: 1'b0, n: 1'b0, c: 1'b0, v: 1'b0};

endpackage

// File: rtl/intu_alu_addsub.sv
module intu_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         use_c_i,
  input  logic         c_stored_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    cin     = sub_i ? ~(use_c_i & c_stored_i) : (use_c_i & c_stored_i);
    wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum_o   = wide[W-1:0];
    carry_o = sub_i ? ~wide[W] : wide[W];
    ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end

endmodule

// File: rtl/intu_alu_logic.sv
module intu_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (fn_i)
        2'd0:    res_o[i] = a_i[i] & b_i[i];
        2'd1:    res_o[i] = a_i[i] | b_i[i];
        2'd2:    res_o[i] = a_i[i] | ~b_i[i];
        default: res_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/intu_alu_ccr.sv
module intu_alu_ccr
  import intu_alu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  ccr_t flags_i,
  output ccr_t ccr_o
);
  ccr_t ccr_q, ccr_d;

  always_comb begin
    ccr_d = ccr_q;
    if (load_i) ccr_d = flags_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccr_q <= CCR_CLEAR;
    else         ccr_q <= ccr_d;
  end

  assign ccr_o = ccr_q;

endmodule

// File: rtl/intu_alu.sv
module intu_alu
  import intu_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         upd_cc_i,
  output logic [W-1:0] result_o,
  output logic         res_valid_o,
  output logic         z_o,
  output logic         n_o,
  output logic         c_o,
  output logic         v_o
);
  localparam int MSB = W - 1;

  alu_op_e      op;
  logic         is_arith, is_sub, use_c, is_cmp, load_cc;
  logic [W-1:0] arith_res, logic_res;
  logic         arith_c, arith_v;
  ccr_t         ccr_q, flags_new;

  assign op = alu_op_e'(op_i);

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDX) ||
               (op == OP_SUBX) || (op == OP_CMP);
    is_sub   = (op == OP_SUB) || (op == OP_SUBX) || (op == OP_CMP);
    use_c    = (op == OP_ADDX) || (op == OP_SUBX);
    is_cmp   = (op == OP_CMP);
    load_cc  = upd_cc_i || is_cmp;
  end

  intu_alu_addsub #(.W(W)) u_addsub (
    .a_i        (opa_i),
    .b_i        (opb_i),
    .sub_i      (is_sub),
    .use_c_i    (use_c),
    .c_stored_i (ccr_q.c),
    .sum_o      (arith_res),
    .carry_o    (arith_c),
    .ovf_o      (arith_v)
  );

  intu_alu_logic #(.W(W)) u_logic (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .fn_i  (op_i[1:0]),
    .res_o (logic_res)
  );

  always_comb begin
    result_o    = is_arith ? arith_res : logic_res;
    res_valid_o = !is_cmp;
    flags_new.z = (result_o == '0);
    flags_new.n = result_o[MSB];
    flags_new.c = is_arith ? arith_c : 1'b0;
    flags_new.v = is_arith ? arith_v : 1'b0;
  end

  intu_alu_ccr u_ccr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_cc),
    .flags_i (flags_new),
    .ccr_o   (ccr_q)
  );

  assign z_o = ccr_q.z;
  assign n_o = ccr_q.n;
  assign c_o = ccr_q.c;
  assign v_o = ccr_q.v;

endmodule

// File: rtl/intu_alu_chk.sv
module intu_alu_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   op_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         upd_cc_i,
  input logic [W-1:0] result_o,
  input logic         res_valid_o,
  input logic         z_o,
  input logic         n_o,
  input logic         c_o,
  input logic         v_o
);
  logic upd;
  logic is_logic;
  assign upd      = upd_cc_i || (op_i == 3'd7);
  assign is_logic = (op_i == 3'd4) || (op_i == 3'd5) || (op_i == 3'd6);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert ({z_o, n_o, c_o, v_o} == 4'b0000);
    end
  end

  assert_cc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable({z_o, n_o, c_o, v_o}));

  assert_zero_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (z_o == ($past(result_o) == '0)));

  assert_neg_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (n_o == $past(result_o[W-1])));

  assert_add_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_cc_i && (op_i == 3'd0)) |=>
      (v_o == $past((opa_i[W-1] == opb_i[W-1]) && (result_o[W-1] != opa_i[W-1]))));

  assert_logic_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_cc_i && is_logic) |=> (!c_o && !v_o));

  assert_cmp_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7) |-> !res_valid_o);

endmodule

bind intu_alu intu_alu_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .upd_cc_i    (upd_cc_i),
  .result_o    (result_o),
  .res_valid_o (res_valid_o),
  .z_o         (z_o),
  .n_o         (n_o),
  .c_o         (c_o),
  .v_o         (v_o)
);

// File: tb/intu_alu_bench.sv
`timescale 1ns/1ps
module intu_alu_bench;
  localparam int W    = 4;
  localparam int MOD  = 1 << W;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   op;
  logic [W-1:0] a, b;
  logic         upd;
  logic [W-1:0] res;
  logic         rv, z, n, c, v;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  intu_alu #(.W(W)) u_intu_alu (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
    .upd_cc_i(upd), .result_o(res), .res_valid_o(rv),
    .z_o(z), .n_o(n), .c_o(c), .v_o(v)
  );

  function automatic int sx(int x);
    return (x >= MOD / 2) ? x - MOD : x;
  endfunction

  // Reference model from R5, R6, R8, R9; returns {r, valid, z, n, c, v}.
  task automatic model(input int o, input int x, input int y, input int cin,
                       output int r, output bit vl, output bit [3:0] f);
    int s, ss;
    bit cf, vf;
    cf = 0; vf = 0; r = 0;
    case (o)
      0, 2: begin
        s  = x + y + ((o == 2) ? cin : 0);
        ss = sx(x) + sx(y) + ((o == 2) ? cin : 0);
        r  = s % MOD; cf = (s >= MOD); vf = (ss > SMAX) || (ss < SMIN);
      end
      1, 3, 7: begin
        s  = x - y - ((o == 3) ? cin : 0);
        ss = sx(x) - sx(y) - ((o == 3) ? cin : 0);
        r  = (s + 2 * MOD) % MOD; cf = (s < 0); vf = (ss > SMAX) || (ss < SMIN);
      end
      4: r = x & y;
      5: r = x | y;
      default: r = (x | (~y & (MOD - 1))) & (MOD - 1);
    endcase
    vl = (o != 7);
    f  = {r == 0, r >= MOD / 2, cf, vf};
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (op=%0d a=%0h b=%0h)", req, act, exp, op, a, b);
    end
  endtask

  task automatic step(input int o, input int x, input int y, input bit u);
    @(negedge clk);
    op = 3'(o); a = W'(x); b = W'(y); upd = u;
  endtask

  initial begin
    rst_n = 1'b0; op = '0; a = '0; b = '0; upd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk({z, n, c, v} == 4'b0, "R1 reset flags", {z, n, c, v}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < MOD; x++) begin
        for (int y = 0; y < MOD; y++) begin
          for (int ci = 0; ci < 2; ci++) begin
            int r, r2; bit vl, vl2; bit [3:0] f, f2;
            // prime stored C through an updating add (R7)
            step(0, ci ? MOD - 1 : 0, ci, 1'b1);
            @(posedge clk); #1;
            chk(c == ci[0], "R7 carry prime", c, ci);
            // operation with update requested
            step(o, x, y, 1'b1);
            #1;
            model(o, x, y, ci, r, vl, f);
            chk(res == W'(r), (o < 4 || o == 7) ? "R5/R6 result" : "R8 result", res, r);
            chk(rv == vl, "R9 valid", rv, vl);
            @(posedge clk); #1;
            chk({z, n, c, v} == f, "R3/R4/R5/R6/R8 flags", {z, n, c, v}, f);
            // swapped operands without update: hold, except compare (R2, R9)
            step(o, y, x, 1'b0);
            @(posedge clk); #1;
            if (o == 7) begin
              model(7, y, x, 0, r2, vl2, f2);
              chk({z, n, c, v} == f2, "R9 compare updates", {z, n, c, v}, f2);
            end else begin
              chk({z, n, c, v} == f, "R2 hold flags", {z, n, c, v}, f);
            end
          end
        end
      end
    end

    // asynchronous reset in mid-cycle clears flags (R1)
    step(1, 0, 1, 1'b1);
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    chk({z, n, c, v} == 4'b0, "R1 async reset", {z, n, c, v}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule